// File: doc/BRIEF.md
# Prescaled Free-Running Interval Timer

This block is a free-running up-counter with a programmable prescaler, meant for a small microcontroller. Its input is either the system clock or a one-cycle tick from an internal RC oscillator, chosen by a control bit. The prescaler divides that input by a power of two from 8 to 1024 and advances the count once per divided pulse. Software cannot stop the counter. It can only restart it from zero.

Reads and writes share one bus address. A read always returns the live count. A write goes to a write-only control register that holds the ratio select, the source select, a self-clearing restart bit and a flag-clear bit. When the count wraps from its maximum to zero, the block sets an interrupt flag. It also emits a one-cycle pulse that serves as the time base for an external watchdog counter.

Top module: `ivt_timer`

## Requirements
- R1: After reset the count, the prescaler, the ratio select and the source select are zero (divide by 8, system clock), and `irq_flag_o` and `wdt_tick_o` are low.
- R2: The count advances by one every 2^(S+3) prescaler input events, where S is control bits [2:0] (0 = divide by 8 up to 7 = divide by 1024). After a restart, the count after N system-clock edges is floor(N / 2^(S+3)).
- R3: Control bit 4 selects the prescaler input. At 0 every clock edge is an event. At 1 only edges with `osc_tick_i` high are events, and with `osc_tick_i` held low the count does not move.
- R4: `rd_data_o` always shows the live count. A control write never loads the count, and changing the source select leaves the count unchanged.
- R5: When the count wraps from all ones to zero, `irq_flag_o` is high in the first cycle after the wrapping edge.
- R6: `wdt_tick_o` is high for exactly the one cycle after the wrapping edge, in which the count reads zero.
- R7: A write with control bit 3 set zeroes the count and the prescaler at the next clock edge. The bit then clears itself, so counting resumes, and the first increment comes a full 2^(S+3) events after that edge.
- R8: If a restart and an increment fall on the same edge, the restart wins and the count becomes zero.
- R9: `irq_flag_o` stays high until `irq_ack_i` is high at an edge or a control write has bit 7 set. A wrap on the same edge as either clear leaves the flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe for the shared address (control register) |
| bus_wdata_i | input | 8 | Write data: [2:0] ratio, [3] restart, [4] RC source, [7] flag clear |
| rd_data_o | output | 8 | Live count, read at the shared address |
| osc_tick_i | input | 1 | Synchronized one-cycle RC oscillator tick |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| irq_flag_o | output | 1 | Overflow interrupt flag |
| wdt_tick_o | output | 1 | One-cycle overflow pulse for the watchdog |

## Verification
Two collisions can occur on one edge. The first is an overflow that coincides with an acknowledge. The bench provokes it by raising `irq_ack_i` for exactly the edge that wraps 255 to 0, 2048 edges after a restart at divide by 8, and it passes only if the flag is high afterwards. The second is a restart that coincides with a prescaler pulse. The bench times the restart write so that its clearing edge is one on which the prescaler would fire. It then checks that the count is zero and that the next increment comes a full eight edges later.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   // control register bit positions
   localparam int unsigned CTL_SEL_LSB  = 0;
   localparam int unsigned CTL_RST_BIT  = 3;
   localparam int unsigned CTL_SRC_BIT  = 4;
   localparam int unsigned CTL_FCLR_BIT = 7;
   localparam int unsigned CTL_MIN_W    = 8;

   typedef enum logic {
      SRC_SYS = 1'b0,
      SRC_RC  = 1'b1
   } src_e;
endpackage

// File: rtl/ivt_ctrl_reg.sv
module ivt_ctrl_reg
   import ivt_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SEL_W  = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [SEL_W-1:0]  sel_o,
   output src_e              src_o,
   output logic              restart_o,
   output logic              flag_clr_o
);
   generate
      if (DATA_W < CTL_MIN_W) begin : g_bad_w
         $error("ivt_ctrl_reg: DATA_W too small for control layout");
      end
      if (SEL_W + CTL_SEL_LSB > CTL_RST_BIT) begin : g_bad_sel
         $error("ivt_ctrl_reg: ratio field overlaps restart bit");
      end
   endgenerate

   logic [SEL_W-1:0] sel_q;
   src_e             src_q;
   logic             restart_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q     <= '0;
         src_q     <= SRC_SYS;
         restart_q <= 1'b0;
      end else begin
         restart_q <= wr_i & wdata_i[CTL_RST_BIT];
         if (wr_i) begin
            sel_q <= wdata_i[CTL_SEL_LSB +: SEL_W];
            src_q <= src_e'(wdata_i[CTL_SRC_BIT]);
         end
      end
   end

   assign sel_o      = sel_q;
   assign src_o      = src_q;
   assign restart_o  = restart_q;
   assign flag_clr_o = wr_i & wdata_i[CTL_FCLR_BIT];

   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

   // R7
   restart_self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (restart_q && !wr_i) |=> !restart_q);
endmodule

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
   import ivt_pkg::*;
#(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned MIN_LOG  = 3,
   parameter bit          RC_EN    = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  src_e             src_i,
   input  logic             osc_tick_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int unsigned NTAP  = 2 ** SEL_W;
   localparam int unsigned PRE_W = MIN_LOG + NTAP - 1;

   generate
      if (MIN_LOG < 1) begin : g_bad_log
         $error("ivt_prescaler: MIN_LOG must be at least 1");
      end
   endgenerate

   logic             evt;
   logic [PRE_W-1:0] div_q;
   logic [NTAP-1:0]  tap;

   generate
      if (RC_EN) begin : g_src_mux
         assign evt = (src_i == SRC_RC) ? osc_tick_i : 1'b1;
      end else begin : g_src_fixed
         logic unused_src;
         assign unused_src = osc_tick_i ^ src_i;
         assign evt = 1'b1;
      end
   endgenerate

   // one tap per ratio: fires when the low (k+MIN_LOG) bits are all ones
   for (genvar k = 0; k < NTAP; k++) begin : g_tap
      assign tap[k] = &div_q[k+MIN_LOG-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       div_q <= '0;
      else if (restart_i) div_q <= '0;
      else if (evt)      div_q <= div_q + 1'b1;
   end

   assign tick_o = evt & tap[sel_i];

   // R7
   restart_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> !tick_o);
   // R3
   rc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_i == SRC_RC && !osc_tick_i) |-> !tick_o);
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cnt_q <= '0;
      else if (restart_i) cnt_q <= '0;
      else if (tick_i)    cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = tick_i & ~restart_i & (cnt_q == CNT_MAX);

   // R8
   restart_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> (cnt_q == '0));
   // R2
   step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !restart_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
   // R4
   hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ivt_irq.sv
module ivt_irq (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wrap_i,
   input  logic ack_i,
   input  logic flag_clr_i,
   output logic flag_o,
   output logic wdt_tick_o
);
   logic flag_q;
   logic wdt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
         wdt_q  <= 1'b0;
      end else begin
         wdt_q <= wrap_i;
         if (wrap_i)                  flag_q <= 1'b1;
         else if (ack_i || flag_clr_i) flag_q <= 1'b0;
      end
   end

   assign flag_o     = flag_q;
   assign wdt_tick_o = wdt_q;

   // R5
   wrap_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_i |=> flag_q);
   // R9
   flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !ack_i && !flag_clr_i) |=> flag_q);
   // R6
   wdt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wdt_q && !wrap_i) |=> !wdt_q);
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
   import ivt_pkg::*;
#(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned SEL_W   = 3,
   parameter int unsigned MIN_LOG = 3,
   parameter bit          RC_EN   = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bus_wr_i,
   input  logic [CNT_W-1:0] bus_wdata_i,
   output logic [CNT_W-1:0] rd_data_o,
   input  logic             osc_tick_i,
   input  logic             irq_ack_i,
   output logic             irq_flag_o,
   output logic             wdt_tick_o
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("ivt_timer: CNT_W must be at least 2");
      end
   endgenerate

   logic [SEL_W-1:0] sel;
   src_e             src;
   logic             restart;
   logic             flag_clr;
   logic             tick;
   logic             wrap;
   logic [CNT_W-1:0] cnt;

   ivt_ctrl_reg #(.DATA_W(CNT_W), .SEL_W(SEL_W)) ctrl_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (bus_wr_i),
      .wdata_i    (bus_wdata_i),
      .sel_o      (sel),
      .src_o      (src),
      .restart_o  (restart),
      .flag_clr_o (flag_clr)
   );

   ivt_prescaler #(.SEL_W(SEL_W), .MIN_LOG(MIN_LOG), .RC_EN(RC_EN)) pre_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .restart_i  (restart),
      .src_i      (src),
      .osc_tick_i (osc_tick_i),
      .sel_i      (sel),
      .tick_o     (tick)
   );

   ivt_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .tick_i    (tick),
      .cnt_o     (cnt),
      .wrap_o    (wrap)
   );

   ivt_irq irq_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wrap_i     (wrap),
      .ack_i      (irq_ack_i),
      .flag_clr_i (flag_clr),
      .flag_o     (irq_flag_o),
      .wdt_tick_o (wdt_tick_o)
   );

   assign rd_data_o = cnt;

   // R6
   wdt_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wdt_tick_o |-> (rd_data_o == '0));
endmodule

// File: tb/ivt_timer_tb.sv
module ivt_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] rd_data;
   logic       osc_tick = 1'b0;
   logic       irq_ack = 1'b0;
   logic       irq_flag;
   logic       wdt_tick;

   int nchk = 0;
   int nerr = 0;

   always #10 clk = ~clk;

   ivt_timer dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_wr_i    (bus_wr),
      .bus_wdata_i (bus_wdata),
      .rd_data_o   (rd_data),
      .osc_tick_i  (osc_tick),
      .irq_ack_i   (irq_ack),
      .irq_flag_o  (irq_flag),
      .wdt_tick_o  (wdt_tick)
   );

   // {ratio select, source, edges after restart, expected count}
   localparam int NVEC = 9;
   localparam logic [31:0] VEC [NVEC] = '{
      {4'd0, 4'd0, 16'd100,  8'd12},
      {4'd1, 4'd0, 16'd100,  8'd6},
      {4'd2, 4'd0, 16'd200,  8'd6},
      {4'd3, 4'd0, 16'd640,  8'd10},
      {4'd4, 4'd0, 16'd1000, 8'd7},
      {4'd5, 4'd0, 16'd3000, 8'd11},
      {4'd6, 4'd0, 16'd6000, 8'd11},
      {4'd7, 4'd0, 16'd9000, 8'd8},
      {4'd0, 4'd1, 16'd500,  8'd0}
   };

   task automatic chk(input int act, input int exp, input string tag);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // called at a negedge; write lands on the next posedge
   task automatic wr(input logic [7:0] d);
      bus_wr    = 1'b1;
      bus_wdata = d;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = '0;
   endtask

   // write with the restart bit, then pass the clearing edge
   task automatic restart(input logic [7:0] d);
      wr(d | 8'h08);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rd_data, 0, "R1 count at reset");
      chk(irq_flag, 0, "R1 flag at reset");
      chk(wdt_tick, 0, "R1 wdt tick at reset");
      rst_n = 1'b1;
      // R1: default ratio /8 from system clock
      repeat (16) @(negedge clk);
      chk(rd_data, 2, "R1 default divide by 8");

      // R2 / R3 table of ratios and sources
      for (int i = 0; i < NVEC; i++) begin
         logic [3:0]  s;
         logic [3:0]  src;
         logic [15:0] n;
         logic [7:0]  e;
         {s, src, n, e} = VEC[i];
         restart({3'b000, src[0], 1'b0, s[2:0]});
         repeat (int'(n)) @(negedge clk);
         chk(rd_data, int'(e), src[0] ? "R3 rc source idle" : "R2 ratio vector");
      end

      // R3 RC ticks drive the prescaler
      restart(8'h10);
      for (int p = 0; p < 20; p++) begin
         osc_tick = 1'b1;
         @(negedge clk);
         osc_tick = 1'b0;
         repeat (2) @(negedge clk);
      end
      chk(rd_data, 2, "R3 rc ticks counted");
      // R4 source change and write leave count untouched
      wr(8'h00);
      chk(rd_data, 2, "R4 source switch keeps count");

      // R5 / R6 overflow
      restart(8'h00);
      repeat (2047) @(negedge clk);
      chk(rd_data, 255, "R5 count before wrap");
      chk(irq_flag, 0, "R5 flag before wrap");
      @(negedge clk);
      chk(rd_data, 0, "R5 count after wrap");
      chk(irq_flag, 1, "R5 flag after wrap");
      chk(wdt_tick, 1, "R6 wdt tick after wrap");
      @(negedge clk);
      chk(wdt_tick, 0, "R6 wdt tick one cycle");
      chk(irq_flag, 1, "R9 flag held");

      // R9 acknowledge clears
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      chk(irq_flag, 0, "R9 ack clears flag");

      // R9 wrap and ack on the same edge
      restart(8'h00);
      repeat (2047) @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      chk(irq_flag, 1, "R9 wrap beats ack");

      // R9 bus write with bit 7 clears
      wr(8'h80);
      chk(irq_flag, 0, "R9 write clears flag");

      // R7 / R8 restart on an edge where the prescaler fires
      restart(8'h00);
      repeat (38) @(negedge clk);
      wr(8'h08);
      chk(rd_data, 4, "R7 count before clearing edge");
      @(negedge clk);
      chk(rd_data, 0, "R8 restart beats increment");
      repeat (7) @(negedge clk);
      chk(rd_data, 0, "R7 full period after restart");
      @(negedge clk);
      chk(rd_data, 1, "R7 first increment after restart");
      repeat (8) @(negedge clk);
      chk(rd_data, 2, "R7 restart bit self clears");

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule